// File: doc/BRIEF.md
# Load-Store Lane Steering and Extension Unit

This unit sits between a processor core and a 32-bit data memory with a one-cycle read latency. For each request it forms the effective byte address from a base value and a signed 16-bit displacement. It then drives the word address, the byte enables and lane-steered write data to the memory in the same cycle.

When the read word returns one cycle later, the unit picks out the addressed byte or half-word using the access information it registered with the request. It then widens that field to 32 bits with sign or zero fill. Lanes are numbered big-endian: byte offset 0 is bits 31:24 of the memory word. The unit checks natural alignment, raises a one-cycle flag for an access that breaks it, blocks the memory access and returns zero in place of load data.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits. `mem_addr` carries bits 31:2 of that sum in the cycle of the request.
- R2: Size encoding is 00 byte, 01 half, 10 word (11 is treated as word). An aligned store raises `mem_we` and drives `mem_be` only for the addressed lanes, where `mem_be[3]` covers bits 31:24. Byte offsets 0..3 give 1000, 0100, 0010, 0001. Half offsets 0 and 2 give 1100 and 0011. A word gives 1111.
- R3: Store data is replicated across the lanes: a byte store drives `{4{wdata[7:0]}}`, a half store drives `{2{wdata[15:0]}}` and a word store drives the data unchanged.
- R4: `load_valid` is high exactly in the cycle after a load request, and `load_data` is valid in that cycle.
- R5: A load selects lanes big-endian. A byte at offset k comes from bits 31-8k down to 24-8k. A half at offset 0 comes from bits 31:16, and a half at offset 2 comes from bits 15:0.
- R6: Signed byte and half loads (`req_unsigned`=0) copy the field's top bit into all upper bits.
- R7: Unsigned byte and half loads (`req_unsigned`=1) fill the upper bits with zeros.
- R8: A half access with effective address bit 0 set is misaligned. So is a word access with either of address bits 1:0 set. Byte accesses are never misaligned. `misalign` is high for exactly the one cycle after a misaligned request.
- R9: A misaligned store keeps `mem_we` low and `mem_be` zero, so memory contents are unchanged.
- R10: A misaligned load still produces `load_valid`, with `load_data` equal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 00 byte, 01 half, 10 word |
| req_unsigned | input | 1 | Zero-extend byte/half loads |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed byte displacement |
| req_wdata | input | 32 | Store data, right-justified |
| mem_en | output | 1 | Memory access enable (aligned requests only) |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Read word, one cycle after `mem_en` |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Extended load result |
| misalign | output | 1 | Previous request was misaligned |

## Verification
The assertions assume that the memory returns the read word exactly one cycle after `mem_en`. They also assume that `req_size`, `req_unsigned` and the address inputs are stable and known whenever `req_valid` is high. The bench drives every request at a falling edge and holds it for one full cycle. Its memory model registers its read output on the rising edge. Between requests, `req_valid` is kept low, so each registered result can be sampled before the next request is issued.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 16,
  parameter int LANE_BITS = 2
) (
  input  logic [ADDR_W-1:0]     base,
  input  logic [OFF_W-1:0]      offset,
  input  lsu_lane_pkg::acc_size_e size,
  output logic [ADDR_W-1:0]     eff_addr,
  output logic                  misaligned
);
  import lsu_lane_pkg::*;

  assign eff_addr = base + {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};

  always_comb begin
    unique case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = eff_addr[0];
      default: misaligned = |eff_addr[LANE_BITS-1:0];
    endcase
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LB    = $clog2(LANES)
) (
  input  lsu_lane_pkg::acc_size_e size,
  input  logic [LB-1:0]         lane_off,
  input  logic [DATA_W-1:0]     wdata_in,
  output logic [LANES-1:0]      be,
  output logic [DATA_W-1:0]     wdata
);
  import lsu_lane_pkg::*;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LB-1:0] OFFV = LB'(LANES - 1 - i);
    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          be[i]           = (lane_off == OFFV);
          wdata[8*i +: 8] = wdata_in[7:0];
        end
        SZ_HALF: begin
          be[i]           = (lane_off[LB-1:1] == OFFV[LB-1:1]);
          wdata[8*i +: 8] = (i % 2 == 1) ? wdata_in[15:8] : wdata_in[7:0];
        end
        default: begin
          be[i]           = 1'b1;
          wdata[8*i +: 8] = wdata_in[8*i +: 8];
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LB    = $clog2(LANES)
) (
  input  lsu_lane_pkg::acc_size_e size,
  input  logic [LB-1:0]         lane_off,
  input  logic                  is_unsigned,
  input  logic                  force_zero,
  input  logic [DATA_W-1:0]     rdata,
  output logic [DATA_W-1:0]     data
);
  import lsu_lane_pkg::*;

  logic [7:0]  byte_v;
  logic [15:0] half_v;

  always_comb begin
    byte_v = '0;
    for (int i = 0; i < LANES; i++)
      if (lane_off == LB'(LANES - 1 - i)) byte_v = rdata[8*i +: 8];
  end

  always_comb begin
    half_v = '0;
    for (int j = 0; j < LANES/2; j++)
      if (lane_off[LB-1:1] == (LB-1)'((LANES - 2 - 2*j) / 2)) half_v = rdata[16*j +: 16];
  end

  always_comb begin
    if (force_zero) data = '0;
    else begin
      unique case (size)
        SZ_BYTE: data = {{(DATA_W-8){byte_v[7] & ~is_unsigned}}, byte_v};
        SZ_HALF: data = {{(DATA_W-16){half_v[15] & ~is_unsigned}}, half_v};
        default: data = rdata;
      endcase
    end
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES = DATA_W / 8,
  localparam int LB    = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_store,
  input  logic [1:0]         req_size,
  input  logic               req_unsigned,
  input  logic [ADDR_W-1:0]  req_base,
  input  logic [OFF_W-1:0]   req_offset,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               mem_en,
  output logic               mem_we,
  output logic [ADDR_W-LB-1:0] mem_addr,
  output logic [LANES-1:0]   mem_be,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               load_valid,
  output logic [DATA_W-1:0]  load_data,
  output logic               misalign
);
  import lsu_lane_pkg::*;

  acc_size_e         size_in;
  logic [ADDR_W-1:0] eff_addr;
  logic              mis_now;
  logic [LANES-1:0]  steer_be;

  acc_size_e         size_q;
  logic [LB-1:0]     off_q;
  logic              uns_q;
  logic              ld_valid_q;
  logic              mis_q;

  assign size_in = acc_size_e'(req_size);

  lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_BITS(LB)) u_agen (
    .base(req_base), .offset(req_offset), .size(size_in),
    .eff_addr(eff_addr), .misaligned(mis_now)
  );

  lsu_store_steer #(.DATA_W(DATA_W)) u_steer (
    .size(size_in), .lane_off(eff_addr[LB-1:0]), .wdata_in(req_wdata),
    .be(steer_be), .wdata(mem_wdata)
  );

  assign mem_en   = req_valid & ~mis_now;
  assign mem_we   = mem_en & req_store;
  assign mem_be   = steer_be & {LANES{mem_we}};
  assign mem_addr = eff_addr[ADDR_W-1:LB];

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid_q <= 1'b0;
      mis_q      <= 1'b0;
      size_q     <= SZ_WORD;
      off_q      <= '0;
      uns_q      <= 1'b0;
    end else begin
      ld_valid_q <= req_valid & ~req_store;
      mis_q      <= req_valid & mis_now;
      if (req_valid & ~req_store) begin
        size_q <= size_in;
        off_q  <= eff_addr[LB-1:0];
        uns_q  <= req_unsigned;
      end
    end
  end

  lsu_load_extract #(.DATA_W(DATA_W)) u_extract (
    .size(size_q), .lane_off(off_q), .is_unsigned(uns_q),
    .force_zero(mis_q | ~ld_valid_q), .rdata(mem_rdata), .data(load_data)
  );

  assign load_valid = ld_valid_q;
  assign misalign   = mis_q;
endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_store,
  input logic [1:0]  req_size,
  input logic        req_unsigned,
  input logic [31:0] req_base,
  input logic [15:0] req_offset,
  input logic        mem_we,
  input logic [3:0]  mem_be,
  input logic        load_valid,
  input logic [31:0] load_data,
  input logic        misalign
);
  logic [1:0] lo;
  logic       ok;
  assign lo = req_base[1:0] + req_offset[1:0];
  assign ok = (req_size == 2'b00) ? 1'b1 :
              (req_size == 2'b01) ? ~lo[0] : (lo == 2'b00);

  p_we_only_aligned_store_r9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (req_valid && req_store && ok));
  p_mis_store_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_store && !ok) |-> (!mem_we && mem_be == 4'b0000));
  p_flag_follows_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ok) |=> misalign);
  p_flag_cause_r8: assert property (@(posedge clk) disable iff (rst)
    misalign |-> $past(req_valid && !ok));
  p_valid_cause_r4: assert property (@(posedge clk) disable iff (rst)
    load_valid |-> $past(req_valid && !req_store));
  p_mis_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (load_valid && misalign) |-> load_data == 32'h0);
  p_byte_one_lane_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_we && req_size == 2'b00) |-> $countones(mem_be) == 1);
  p_ubyte_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (load_valid && $past(req_size == 2'b00 && req_unsigned)) |-> load_data[31:8] == 24'h0);
endmodule

bind lsu_lane_unit lsu_lane_unit_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
  .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
  .req_offset(req_offset), .mem_we(mem_we), .mem_be(mem_be),
  .load_valid(load_valid), .load_data(load_data), .misalign(misalign)
);

// File: tb/lsu_lane_unit_bench.sv
`timescale 1ns/1ps
module lsu_lane_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
  logic [1:0]  req_size = 2'b10;
  logic [31:0] req_base = '0, req_wdata = '0;
  logic [15:0] req_offset = '0;
  logic        mem_en, mem_we, load_valid, misalign;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, load_data;
  logic [31:0] mem_rdata = '0;
  logic [31:0] ram [16];
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  lsu_lane_unit u_lsu_lane_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
    .req_offset(req_offset), .req_wdata(req_wdata), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .load_valid(load_valid),
    .load_data(load_data), .misalign(misalign)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) ram[mem_addr[3:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
      mem_rdata <= ram[mem_addr[3:0]];
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic store_op(logic [31:0] base, logic [15:0] off, logic [1:0] sz,
                          logic [31:0] d, logic [3:0] exp_be, logic [31:0] exp_wd,
                          logic exp_we, logic [29:0] exp_addr, string tag);
    @(negedge clk);
    req_valid = 1; req_store = 1; req_size = sz; req_base = base;
    req_offset = off; req_wdata = d; req_unsigned = 0;
    #1;
    check({tag, " we"}, {31'b0, mem_we}, {31'b0, exp_we});
    check({tag, " be"}, {28'b0, mem_be}, {28'b0, exp_be});
    check({tag, " addr"}, {2'b0, mem_addr}, {2'b0, exp_addr});
    if (exp_we) check({tag, " wdata"}, mem_wdata, exp_wd);
    @(negedge clk);
    req_valid = 0;
    check({tag, " misalign"}, {31'b0, misalign}, {31'b0, ~exp_we});
  endtask

  task automatic load_op(logic [31:0] base, logic [15:0] off, logic [1:0] sz,
                         logic uns, logic [31:0] exp_d, logic exp_mis, string tag);
    @(negedge clk);
    req_valid = 1; req_store = 0; req_size = sz; req_base = base;
    req_offset = off; req_unsigned = uns;
    #1;
    check({tag, " no-write"}, {31'b0, mem_we}, 32'h0);
    @(negedge clk);
    req_valid = 0;
    check({tag, " valid"}, {31'b0, load_valid}, 32'h1);
    check({tag, " data"}, load_data, exp_d);
    check({tag, " misalign"}, {31'b0, misalign}, {31'b0, exp_mis});
  endtask

  task automatic t_reset();
    check("R4 reset load_valid", {31'b0, load_valid}, 32'h0);
    check("R8 reset misalign", {31'b0, misalign}, 32'h0);
  endtask

  task automatic t_word_and_address();
    store_op(32'h10, 16'h0, 2'b10, 32'h8190A2B3, 4'b1111, 32'h8190A2B3, 1, 30'h4, "R1 R2 R3 word store");
    store_op(32'h24, 16'hFFFC, 2'b10, 32'h12345678, 4'b1111, 32'h12345678, 1, 30'h8, "R1 negative offset store");
    load_op(32'h10, 16'h0, 2'b10, 0, 32'h8190A2B3, 0, "R4 word load");
    load_op(32'h30, 16'hFFF0, 2'b10, 0, 32'h12345678, 0, "R1 negative offset load");
  endtask

  task automatic t_byte_half_loads();
    load_op(32'h10, 16'h0, 2'b00, 0, 32'hFFFFFF81, 0, "R5 R6 byte off0 signed");
    load_op(32'h10, 16'h1, 2'b00, 1, 32'h00000090, 0, "R5 R7 byte off1 unsigned");
    load_op(32'h11, 16'h1, 2'b00, 0, 32'hFFFFFFA2, 0, "R5 R6 byte off2 signed");
    load_op(32'h13, 16'h0, 2'b00, 1, 32'h000000B3, 0, "R5 R7 byte off3 unsigned");
    load_op(32'h10, 16'h0, 2'b01, 0, 32'hFFFF8190, 0, "R5 R6 half off0 signed");
    load_op(32'h10, 16'h2, 2'b01, 1, 32'h0000A2B3, 0, "R5 R7 half off2 unsigned");
    load_op(32'h20, 16'h1, 2'b00, 0, 32'h00000034, 0, "R6 positive byte signed");
    load_op(32'h10, 16'h0, 2'b00, 1, 32'h00000081, 0, "R7 negative byte unsigned");
  endtask

  task automatic t_narrow_stores();
    store_op(32'h10, 16'h1, 2'b00, 32'h000000EE, 4'b0100, 32'hEEEEEEEE, 1, 30'h4, "R2 R3 byte store off1");
    store_op(32'h10, 16'h2, 2'b01, 32'h0000CAFE, 4'b0011, 32'hCAFECAFE, 1, 30'h4, "R2 R3 half store off2");
    load_op(32'h10, 16'h0, 2'b10, 0, 32'h81EECAFE, 0, "R2 merged word after narrow stores");
    store_op(32'h23, 16'h0, 2'b00, 32'h00000011, 4'b0001, 32'h11111111, 1, 30'h8, "R2 byte store off3");
    store_op(32'h20, 16'h0, 2'b01, 32'h00002233, 4'b1100, 32'h22332233, 1, 30'h8, "R2 half store off0");
    load_op(32'h20, 16'h0, 2'b10, 0, 32'h22335611, 0, "R2 merged word 2");
  endtask

  task automatic t_misaligned();
    store_op(32'h11, 16'h0, 2'b01, 32'h0000FFFF, 4'b0000, 32'h0, 0, 30'h4, "R9 R8 half store odd");
    store_op(32'h10, 16'h2, 2'b10, 32'hDEADBEEF, 4'b0000, 32'h0, 0, 30'h4, "R9 R8 word store off2");
    @(negedge clk);
    check("R8 flag one cycle", {31'b0, misalign}, 32'h0);
    load_op(32'h10, 16'h0, 2'b10, 0, 32'h81EECAFE, 0, "R9 memory unchanged");
    load_op(32'h10, 16'h3, 2'b01, 0, 32'h0, 1, "R10 R8 half load odd");
    load_op(32'h11, 16'h0, 2'b10, 0, 32'h0, 1, "R10 R8 word load off1");
    load_op(32'h11, 16'h2, 2'b00, 1, 32'h000000FE, 0, "R8 byte off3 never misaligned");
    @(negedge clk);
    check("R8 flag clears", {31'b0, misalign}, 32'h0);
    check("R4 valid clears", {31'b0, load_valid}, 32'h0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < 16; k++) ram[k] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_word_and_address();
    t_byte_half_loads();
    t_narrow_stores();
    t_misaligned();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end
endmodule